// File: doc/BRIEF.md
# SPI Banked Register Command Slave

This block is the host-facing serial front end of a network controller. A host selects it by pulling chip select low, sends one command byte and then zero or more data bytes. The command byte holds a 3-bit opcode in bits 7:5 and a 5-bit register address in bits 4:0. The block turns these commands into reads and writes of a banked control register file, into bit set and bit clear operations, and into streaming reads and writes of a packet buffer memory addressed by auto-incrementing pointers.

Five registers are reachable from every bank and live in the block: interrupt enable, interrupt flags, status, control 2 and control 1. The block also holds the 13-bit buffer read and write pointers, which are banked registers of bank 0. All other banked registers sit outside the block, behind a simple register port with a combinational read. The buffer memory sits behind a port with a one-cycle synchronous read. The SPI pins are sampled with a system clock that runs well above the serial clock.

Top module: `spi_bank_regs`

## Requirements
- R1: After reset, miso is 0 and the block registers read back as: control 1 (0x1F) = 0x00, control 2 (0x1E) = 0x80, interrupt enable (0x1B) = 0x00, buffer read pointer = 0, buffer write pointer = 0.
- R2: Command bytes decode as: 0x00|addr read register, 0x3A read buffer, 0x40|addr write register, 0x7A write buffer, 0x80|addr bit set, 0xA0|addr bit clear, 0xFF soft reset. Opcode 1 or 3 with an address other than 0x1A, and opcode 6, are ignored along with their data bytes.
- R3: SPI mode 0, MSB first. A register read returns the addressed value on miso in every byte that follows the command byte.
- R4: Addresses 0x1B to 0x1F reach the same five registers whichever bank is selected.
- R5: Bits 1:0 of control 1 (0x1F) select the bank; addresses 0x00 to 0x1A in banks 1 to 3, and 0x04 to 0x1A in bank 0, are accessed on the register port at reg_addr = {bank, address}.
- R6: A register write stores each data byte in the addressed register; with several data bytes the last one remains.
- R7: Bit set ORs the data byte into the register and bit clear ANDs it with the inverted data byte; both are ignored for bank 2 addresses 0x00 to 0x1A.
- R8: Each complete data byte of a buffer write is stored at the write pointer, which then advances by one when bit 7 of control 2 is set.
- R9: A buffer read returns the byte at the read pointer in each data byte, and the pointer advances by one for each complete byte when bit 7 of control 2 is set.
- R10: With bit 7 of control 2 clear, buffer reads and writes use the same address for every byte and the pointers do not move.
- R11: Both buffer pointers wrap from 0x1FFF to 0x0000.
- R12: In bank 0, addresses 0x00/0x01 are the read pointer low/high bytes and 0x02/0x03 the write pointer low/high bytes; the high byte holds bits 12:8 and reads 0 in its upper three bits.
- R13: The soft reset command returns every register held in the block, bank selection included, to its R1 value.
- R14: A transaction ends when chip select goes high; a partial byte has no effect, and miso is 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sck |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| reg_addr | output | 7 | Banked register address {bank, address} |
| reg_wr | output | 1 | One-cycle write strobe for the banked register |
| reg_wdata | output | 8 | Write data for the banked register |
| reg_rdata | input | 8 | Combinational read data of the register at reg_addr |
| buf_addr | output | BUF_AW | Buffer memory address |
| buf_rd | output | 1 | Buffer read strobe, data expected next cycle |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| buf_rdata | input | 8 | Buffer read data, held until the next read |

## Verification
The assertions assume the serial clock is slow against clk, so that every edge of sck and cs_n is seen after synchronisation, and that chip select only moves while sck is low and after the last edge has been taken in. They also assume reg_rdata follows reg_addr in the same cycle and that buf_rdata stays put between reads. The bench drives sck with six clk cycles per half period, changes cs_n only with sck low and several cycles clear of any edge, and models the register file and the buffer memory with exactly those read timings.

// File: rtl/spi_bank_regs.sv
module spi_bank_regs #(
  parameter int BUF_AW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic [6:0]        reg_addr,
  output logic              reg_wr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        reg_rdata,
  output logic [BUF_AW-1:0] buf_addr,
  output logic              buf_rd,
  output logic              buf_wr,
  output logic [7:0]        buf_wdata,
  input  logic [7:0]        buf_rdata
);
  localparam logic [2:0] OP_RD  = 3'd0;
  localparam logic [2:0] OP_RB  = 3'd1;
  localparam logic [2:0] OP_WR  = 3'd2;
  localparam logic [2:0] OP_WB  = 3'd3;
  localparam logic [2:0] OP_SET = 3'd4;
  localparam logic [2:0] OP_CLR = 3'd5;
  localparam logic [4:0] A_BUF  = 5'h1A;
  localparam logic [4:0] A_IE   = 5'h1B;
  localparam logic [4:0] A_IF   = 5'h1C;
  localparam logic [4:0] A_ST   = 5'h1D;
  localparam logic [4:0] A_C2   = 5'h1E;
  localparam logic [4:0] A_C1   = 5'h1F;
  localparam logic [7:0] C2_RST = 8'h80;
  localparam logic [7:0] CMD_RB = {OP_RB, A_BUF};
  localparam logic [7:0] CMD_SR = 8'hFF;

  logic [1:0] cs_q, mosi_q;
  logic [2:0] sck_q;
  logic [6:0] rx_sr;
  logic [2:0] bitcnt;
  logic       in_data, load_pend;
  logic [7:0] cmd, tx_sr;
  logic [7:0] r_ie, r_if, r_st, r_c2, r_c1;
  logic [BUF_AW-1:0] rd_ptr, wr_ptr;

  wire sel      = ~cs_q[1];
  wire rise     = sck_q[1] & ~sck_q[2];
  wire fall     = ~sck_q[1] & sck_q[2];
  wire [7:0] byte_in = {rx_sr, mosi_q[1]};
  wire last_bit = sel & rise & (bitcnt == 3'd7);

  wire [2:0] op   = cmd[7:5];
  wire [4:0] ra   = cmd[4:0];
  wire [1:0] bank = r_c1[1:0];
  wire autoinc    = r_c2[7];
  wire common     = ra >= A_IE;
  wire ptr_reg    = (bank == 2'd0) && (ra < 5'd4);
  wire local_reg  = common | ptr_reg;
  wire is_bitop   = (op == OP_SET) | (op == OP_CLR);
  wire bit_ok     = local_reg | (bank != 2'd2);
  wire is_rb      = (op == OP_RB) && (ra == A_BUF);
  wire is_wb      = (op == OP_WB) && (ra == A_BUF);
  wire do_wr      = (op == OP_WR) | (is_bitop & bit_ok);

  wire [15:0] rdp = 16'(rd_ptr);
  wire [15:0] wrp = 16'(wr_ptr);

  logic [7:0] loc_val, reg_val, new_val, tx_next;

  always_comb begin
    case (ra)
      5'h00:   loc_val = rdp[7:0];
      5'h01:   loc_val = rdp[15:8];
      5'h02:   loc_val = wrp[7:0];
      5'h03:   loc_val = wrp[15:8];
      A_IE:    loc_val = r_ie;
      A_IF:    loc_val = r_if;
      A_ST:    loc_val = r_st;
      A_C2:    loc_val = r_c2;
      A_C1:    loc_val = r_c1;
      default: loc_val = 8'h00;
    endcase
  end

  assign reg_val = local_reg ? loc_val : reg_rdata;
  assign new_val = (op == OP_SET) ? (reg_val | byte_in) :
                   (op == OP_CLR) ? (reg_val & ~byte_in) : byte_in;
  assign tx_next = is_rb ? buf_rdata : (op == OP_RD) ? reg_val : 8'h00;
  assign reg_addr = {bank, ra};
  assign miso = sel & tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 2'b11;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
    end else begin
      cs_q   <= {cs_q[0], cs_n};
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr     <= '0;
      bitcnt    <= '0;
      in_data   <= 1'b0;
      load_pend <= 1'b0;
      cmd       <= '0;
      tx_sr     <= '0;
      r_ie      <= '0;
      r_if      <= '0;
      r_st      <= '0;
      r_c2      <= C2_RST;
      r_c1      <= '0;
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      buf_addr  <= '0;
      buf_rd    <= 1'b0;
      buf_wr    <= 1'b0;
      buf_wdata <= '0;
    end else begin
      buf_rd <= 1'b0;
      buf_wr <= 1'b0;
      reg_wr <= 1'b0;
      if (!sel) begin
        bitcnt    <= '0;
        in_data   <= 1'b0;
        load_pend <= 1'b0;
        tx_sr     <= '0;
      end else begin
        if (rise) begin
          rx_sr  <= byte_in[6:0];
          bitcnt <= bitcnt + 3'd1;
        end
        if (fall) begin
          if (load_pend) tx_sr <= tx_next;
          else           tx_sr <= {tx_sr[6:0], 1'b0};
          load_pend <= 1'b0;
        end
        if (last_bit) begin
          load_pend <= 1'b1;
          if (!in_data) begin
            cmd     <= byte_in;
            in_data <= 1'b1;
            if (byte_in == CMD_SR) begin
              r_ie   <= '0;
              r_if   <= '0;
              r_st   <= '0;
              r_c2   <= C2_RST;
              r_c1   <= '0;
              rd_ptr <= '0;
              wr_ptr <= '0;
            end
            if (byte_in == CMD_RB) begin
              buf_rd   <= 1'b1;
              buf_addr <= rd_ptr;
            end
          end else begin
            if (is_rb) begin
              buf_rd   <= 1'b1;
              buf_addr <= autoinc ? rd_ptr + 1'b1 : rd_ptr;
              if (autoinc) rd_ptr <= rd_ptr + 1'b1;
            end
            if (is_wb) begin
              buf_wr    <= 1'b1;
              buf_addr  <= wr_ptr;
              buf_wdata <= byte_in;
              if (autoinc) wr_ptr <= wr_ptr + 1'b1;
            end
            if (do_wr) begin
              if (local_reg) begin
                case (ra)
                  5'h00:   rd_ptr[7:0]        <= new_val;
                  5'h01:   rd_ptr[BUF_AW-1:8] <= new_val[BUF_AW-9:0];
                  5'h02:   wr_ptr[7:0]        <= new_val;
                  5'h03:   wr_ptr[BUF_AW-1:8] <= new_val[BUF_AW-9:0];
                  A_IE:    r_ie <= new_val;
                  A_IF:    r_if <= new_val;
                  A_ST:    r_st <= new_val;
                  A_C2:    r_c2 <= new_val;
                  default: r_c1 <= new_val;
                endcase
              end else begin
                reg_wr    <= 1'b1;
                reg_wdata <= new_val;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_bank_regs_chk.sv
module spi_bank_regs_chk #(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          miso,
  input logic          buf_rd,
  input logic          buf_wr,
  input logic [AW-1:0] buf_addr,
  input logic          reg_wr,
  input logic [6:0]    reg_addr,
  input logic [7:0]    cmd,
  input logic [AW-1:0] wr_ptr,
  input logic          autoinc
);
  assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_rd && buf_wr));

  assert_wr_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && autoinc) |-> (wr_ptr == AW'(buf_addr + 1'b1)));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !autoinc) |-> (wr_ptr == buf_addr));

  assert_bank2_bitop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !((reg_addr[6:5] == 2'd2) && (cmd[7:6] == 2'b10)));

  assert_reg_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_idle_miso_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso);
endmodule

bind spi_bank_regs spi_bank_regs_chk #(.AW(BUF_AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .miso     (miso),
  .buf_rd   (buf_rd),
  .buf_wr   (buf_wr),
  .buf_addr (buf_addr),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .cmd      (cmd),
  .wr_ptr   (wr_ptr),
  .autoinc  (r_c2[7])
);

// File: tb/spi_bank_regs_tb_top.sv
module spi_bank_regs_tb_top;
  localparam int AW = 13;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  logic [6:0] reg_addr;
  logic reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [AW-1:0] buf_addr;
  logic buf_rd, buf_wr;
  logic [7:0] buf_wdata;
  logic [7:0] buf_rdata = 8'h00;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  spi_bank_regs #(.BUF_AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rdata(buf_rdata)
  );

  function automatic logic [7:0] rfv(int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [7:0] ramv(int a);
    return 8'(a) ^ 8'hC3 ^ {7'b0, 1'(a >> 8)};
  endfunction

  logic [7:0] rf [128];
  logic [7:0] mem [512];
  initial begin
    for (int i = 0; i < 128; i++) rf[i] = rfv(i);
    for (int i = 0; i < 512; i++) mem[i] = ramv(i);
  end
  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) begin
    if (reg_wr) rf[reg_addr] <= reg_wdata;
    if (buf_wr) mem[buf_addr[8:0]] <= buf_wdata;
    if (buf_rd) buf_rdata <= mem[buf_addr[8:0]];
  end

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic sel_on();
    @(negedge clk); cs_n = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk); mosi = tx[7 - i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], miso};
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [7:0] v);
    logic [7:0] d;
    sel_on(); xfer({3'd0, a}, d); xfer(8'h00, v); sel_off();
  endtask

  task automatic cmd2(input logic [7:0] c, input logic [7:0] v);
    logic [7:0] d;
    sel_on(); xfer(c, d); xfer(v, d); sel_off();
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] v);
    cmd2({3'd2, a}, v);
  endtask

  task automatic set_wp(input int p);
    wr_reg(5'h02, 8'(p)); wr_reg(5'h03, 8'(p >> 8));
  endtask

  task automatic set_rp(input int p);
    wr_reg(5'h00, 8'(p)); wr_reg(5'h01, 8'(p >> 8));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R14: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, d, e;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset values
    check("R1 miso idle", {7'b0, miso}, 8'h00);
    rd_reg(5'h1F, v); check("R1 ctrl1", v, 8'h00);
    rd_reg(5'h1E, v); check("R1 ctrl2", v, 8'h80);
    rd_reg(5'h1B, v); check("R1 int enable", v, 8'h00);
    rd_reg(5'h00, v); check("R1 read ptr", v, 8'h00);
    rd_reg(5'h02, v); check("R1 write ptr", v, 8'h00);

    // R4 shared registers across banks
    for (int b = 0; b < 4; b++) begin
      wr_reg(5'h1F, 8'(b));
      wr_reg(5'h1B, 8'(8'h10 + b));
      wr_reg(5'h1F, 8'((b + 1) % 4));
      rd_reg(5'h1B, v); check("R4 shared int enable", v, 8'(8'h10 + b));
      rd_reg(5'h1F, v); check("R4 bank readback", v, 8'((b + 1) % 4));
    end

    // R5 / R3 / R6 sweep over banked addresses
    for (int b = 0; b < 4; b++) begin
      wr_reg(5'h1F, 8'(b));
      for (int a = 0; a < 27; a++) begin
        if (b == 0 && a < 4) continue;
        rd_reg(5'(a), v); check("R5 R3 banked read", v, rfv(b * 32 + a));
        wr_reg(5'(a), ~rfv(b * 32 + a));
        rd_reg(5'(a), v); check("R6 banked write", v, ~rfv(b * 32 + a));
      end
    end

    // R3 repeated read, R6 multi-byte write
    wr_reg(5'h1F, 8'h00);
    sel_on(); xfer(8'h1F, d); xfer(8'h00, v); xfer(8'h00, e); sel_off();
    check("R3 first read byte", v, 8'h00);
    check("R3 second read byte", e, 8'h00);
    sel_on(); xfer(8'h5B, d); xfer(8'h11, d); xfer(8'h22, d); sel_off();
    rd_reg(5'h1B, v); check("R6 last byte kept", v, 8'h22);

    // R7 bit set/clear
    wr_reg(5'h1F, 8'h01);
    e = ~rfv(32 + 5);
    cmd2(8'h85, 8'h0F); e = e | 8'h0F;
    rd_reg(5'h05, v); check("R7 bit set bank1", v, e);
    cmd2(8'hA5, 8'h03); e = e & ~8'h03;
    rd_reg(5'h05, v); check("R7 bit clear bank1", v, e);
    wr_reg(5'h1F, 8'h02);
    cmd2(8'h85, 8'hFF);
    rd_reg(5'h05, v); check("R7 bit set ignored bank2", v, ~rfv(64 + 5));
    cmd2(8'hA5, 8'hFF);
    rd_reg(5'h05, v); check("R7 bit clear ignored bank2", v, ~rfv(64 + 5));
    cmd2(8'h9F, 8'h01);
    rd_reg(5'h1F, v); check("R7 bit set ctrl1", v, 8'h03);
    cmd2(8'hBF, 8'h02);
    rd_reg(5'h1F, v); check("R7 bit clear ctrl1", v, 8'h01);

    // R12 pointer bytes, R8 buffer write
    wr_reg(5'h1F, 8'h00);
    wr_reg(5'h03, 8'hFF);
    rd_reg(5'h03, v); check("R12 high byte masked", v, 8'h1F);
    set_wp(16'h0100);
    sel_on(); xfer(8'h7A, d);
    for (int i = 0; i < 5; i++) xfer(8'(8'hA0 + i), d);
    sel_off();
    rd_reg(5'h02, v); check("R8 R12 write ptr low", v, 8'h05);
    rd_reg(5'h03, v); check("R8 R12 write ptr high", v, 8'h01);

    // R9 buffer read
    set_rp(16'h0100);
    sel_on(); xfer(8'h3A, d);
    for (int i = 0; i < 5; i++) begin
      xfer(8'h00, v); check("R9 buffer read data", v, 8'(8'hA0 + i));
    end
    sel_off();
    rd_reg(5'h00, v); check("R9 read ptr advanced", v, 8'h05);

    // R10 auto-increment off
    cmd2(8'hBE, 8'h80);
    rd_reg(5'h1E, v); check("R10 ctrl2 cleared", v, 8'h00);
    set_wp(16'h0020);
    sel_on(); xfer(8'h7A, d); xfer(8'h31, d); xfer(8'h32, d); xfer(8'h33, d); sel_off();
    rd_reg(5'h02, v); check("R10 write ptr held", v, 8'h20);
    set_rp(16'h0020);
    sel_on(); xfer(8'h3A, d); xfer(8'h00, v); xfer(8'h00, e); sel_off();
    check("R10 same address byte 1", v, 8'h33);
    check("R10 same address byte 2", e, 8'h33);
    rd_reg(5'h00, v); check("R10 read ptr held", v, 8'h20);
    cmd2(8'h9E, 8'h80);

    // R11 wrap
    set_rp(16'h1FFE);
    sel_on(); xfer(8'h3A, d);
    xfer(8'h00, v); check("R11 read 0x1FFE", v, ramv(16'h1FE));
    xfer(8'h00, v); check("R11 read 0x1FFF", v, ramv(16'h1FF));
    xfer(8'h00, v); check("R11 read 0x0000", v, ramv(0));
    xfer(8'h00, v); check("R11 read 0x0001", v, ramv(1));
    sel_off();
    rd_reg(5'h00, v); check("R11 read ptr low", v, 8'h02);
    rd_reg(5'h01, v); check("R11 read ptr high", v, 8'h00);
    set_wp(16'h1FFF);
    sel_on(); xfer(8'h7A, d); xfer(8'h77, d); xfer(8'h78, d); sel_off();
    rd_reg(5'h02, v); check("R11 write ptr low", v, 8'h01);
    rd_reg(5'h03, v); check("R11 write ptr high", v, 8'h00);

    // R14 partial byte discarded
    set_wp(16'h0040);
    sel_on(); xfer(8'h7A, d); xfer(8'h55, d); xfer_bits(8'h66, 4, d); sel_off();
    rd_reg(5'h02, v); check("R14 partial byte no advance", v, 8'h41);
    set_rp(16'h0040);
    sel_on(); xfer(8'h3A, d); xfer(8'h00, v); xfer(8'h00, e); sel_off();
    check("R14 full byte written", v, 8'h55);
    check("R14 partial byte not written", e, ramv(16'h41));

    // R2 undefined commands ignored
    set_rp(16'h0010);
    cmd2(8'h60, 8'h99);
    cmd2(8'h20, 8'h99);
    cmd2(8'hC0, 8'h99);
    rd_reg(5'h00, v); check("R2 ignored cmd read ptr", v, 8'h10);
    rd_reg(5'h02, v); check("R2 ignored cmd write ptr", v, 8'h41);

    // R13 soft reset
    wr_reg(5'h1B, 8'h5A);
    wr_reg(5'h1E, 8'h00);
    wr_reg(5'h1F, 8'h03);
    sel_on(); xfer(8'hFF, d); sel_off();
    rd_reg(5'h1F, v); check("R13 ctrl1 reset", v, 8'h00);
    rd_reg(5'h1E, v); check("R13 ctrl2 reset", v, 8'h80);
    rd_reg(5'h1B, v); check("R13 int enable reset", v, 8'h00);
    rd_reg(5'h00, v); check("R13 read ptr reset", v, 8'h00);
    rd_reg(5'h02, v); check("R13 write ptr reset", v, 8'h00);
    check("R14 miso idle", {7'b0, miso}, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule